// File: doc/BRIEF.md
# DRAM DLL Control Sequencer

This block sits in a graphics memory controller and drives the mode-register commands that act on the delay-locked loop inside the DRAM. On request it either resets the DLL with a single mode-register write, or steps through a clock-frequency change. That change is an extended-mode write that turns the DLL off, then a wait for the external clock source to settle, then an extended-mode write that turns the DLL back on, then a lock wait. It also enforces the quiet periods that follow these commands. A short window blocks power-down after a DLL reset. A long lock wait blocks normal traffic after the DLL is enabled again.

Commands leave the block as a one-cycle strobe. The strobe carries a type bit and a 12-bit address. The address is built from the configured mode values, with the DLL control bits laid over them. Requests that arrive while a sequence is running are kept pending and are served once the block is free. A busy flag tells the controller that work is outstanding.

Top module: `dll_seq_ctrl`

## Requirements
- R1: After reset, cmd_vld is 0, pd_allow is 1, traffic_allow is 1 and busy is 0.
- R2: Address bit 7 of every issued command is 0, even when the configured mode value has bit 7 set.
- R3: A DLL-reset request taken while idle produces, one cycle after it is sampled, a command with cmd_type 0 (mode write) and an address equal to mode_cfg with bit 8 forced to 1 and bit 7 forced to 0.
- R4: pd_allow is low for exactly 10 consecutive cycles, starting in the cycle of the DLL-reset command.
- R5: A frequency-change request taken while idle produces a command with cmd_type 1 (extended write) and an address equal to emode_cfg with bit 0 forced to 1 (DLL off) and bit 7 forced to 0. traffic_allow stays 1 while the block waits for the clock.
- R6: The DLL-on command is issued only after clk_stable has been sampled low and then high, following the DLL-off command. It has cmd_type 1 and an address equal to emode_cfg with bits 0 and 7 forced to 0.
- R7: traffic_allow is low for exactly LOCK_CYC cycles, starting in the cycle of the DLL-on command. It falls at no other time, and busy is high throughout that window.
- R8: Requests that arrive while a sequence or lock wait is in progress are held and served in order once it ends. When both requests are pending together, the DLL reset is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 12 | Configured mode-register value |
| emode_cfg | input | 12 | Configured extended mode-register value |
| dll_rst_req | input | 1 | Request a DLL reset |
| freq_chg_req | input | 1 | Request a clock-frequency change sequence |
| clk_stable | input | 1 | External clock source reports a stable clock |
| cmd_vld | output | 1 | One-cycle command strobe |
| cmd_type | output | 1 | 0 = mode write, 1 = extended mode write |
| cmd_addr | output | 12 | Command address bits |
| pd_allow | output | 1 | Power-down may be issued |
| traffic_allow | output | 1 | Normal traffic may be issued |
| busy | output | 1 | Sequence, lock wait or pending request outstanding |

## Verification
The hardest case to reach from the ports is a DLL reset that arrives while a frequency change is halfway through. It has to stay pending through the clock wait and the whole lock wait, and only then go out. The stimulus reaches this by pulsing the reset request while clk_stable is held low after the DLL-off command. The scoreboard then expects the DLL-on command first and the reset command only after traffic_allow has come back. A second case raises both requests in the same cycle, to check the order in which they are served.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RST  = 2'd1,
    KIND_OFF  = 2'd2,
    KIND_ON   = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_LOW = 2'd1,
    ST_WAIT_HI  = 2'd2
  } seq_state_e;

  localparam logic TYPE_MRW  = 1'b0;
  localparam logic TYPE_EMRW = 1'b1;
endpackage

// File: rtl/dll_dn_cnt.sv
module dll_dn_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         running
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign running = (cnt_q != '0);
  assign cnt_en  = load | running;

  always_comb begin
    cnt_d = cnt_q;
    if (load)         cnt_d = load_val;
    else if (running) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dll_cmd_enc.sv
module dll_cmd_enc
  import dll_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int RST_BIT = 8,
  parameter int TST_BIT = 7,
  parameter int OFF_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_e         kind,
  input  logic [ADDR_W-1:0] mode_cfg,
  input  logic [ADDR_W-1:0] emode_cfg,
  output logic              cmd_vld,
  output logic              cmd_type,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam logic [ADDR_W-1:0] RST_MASK = ADDR_W'(1) << RST_BIT;
  localparam logic [ADDR_W-1:0] TST_MASK = ADDR_W'(1) << TST_BIT;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(1) << OFF_BIT;

  logic              vld_d;
  logic              type_d;
  logic [ADDR_W-1:0] addr_d;
  logic              load_en;

  always_comb begin
    vld_d  = 1'b1;
    type_d = TYPE_MRW;
    addr_d = '0;
    case (kind)
      KIND_RST: begin
        type_d = TYPE_MRW;
        addr_d = mode_cfg | RST_MASK;
      end
      KIND_OFF: begin
        type_d = TYPE_EMRW;
        addr_d = emode_cfg | OFF_MASK;
      end
      KIND_ON: begin
        type_d = TYPE_EMRW;
        addr_d = emode_cfg & ~OFF_MASK;
      end
      default: vld_d = 1'b0;
    endcase
    addr_d = addr_d & ~TST_MASK;
  end

  assign load_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_vld <= 1'b0;
    else        cmd_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_type <= TYPE_MRW;
      cmd_addr <= '0;
    end else if (load_en) begin
      cmd_type <= type_d;
      cmd_addr <= addr_d;
    end
  end
endmodule

// File: rtl/dll_seq_fsm.sv
module dll_seq_fsm
  import dll_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dll_rst_req,
  input  logic      freq_chg_req,
  input  logic      clk_stable,
  input  logic      lock_busy,
  output cmd_kind_e kind,
  output logic      seq_busy
);
  seq_state_e state_q, state_d;
  logic       pend_rst_q, pend_rst_d;
  logic       pend_frq_q, pend_frq_d;
  logic       want_rst, want_frq;

  assign want_rst = pend_rst_q | dll_rst_req;
  assign want_frq = pend_frq_q | freq_chg_req;

  always_comb begin
    state_d = state_q;
    kind    = KIND_NONE;
    case (state_q)
      ST_IDLE: begin
        if (!lock_busy) begin
          if (want_rst) begin
            kind = KIND_RST;
          end else if (want_frq) begin
            kind    = KIND_OFF;
            state_d = ST_WAIT_LOW;
          end
        end
      end
      ST_WAIT_LOW: begin
        if (!clk_stable) state_d = ST_WAIT_HI;
      end
      ST_WAIT_HI: begin
        if (clk_stable) begin
          kind    = KIND_ON;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_rst_d = want_rst & (kind != KIND_RST);
    pend_frq_d = want_frq & (kind != KIND_OFF);
  end

  assign seq_busy = (state_q != ST_IDLE) | pend_rst_q | pend_frq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_rst_q <= 1'b0;
      pend_frq_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pend_rst_q <= pend_rst_d;
      pend_frq_q <= pend_frq_d;
    end
  end
endmodule

// File: rtl/dll_seq_ctrl.sv
module dll_seq_ctrl
  import dll_seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PD_GAP   = 10,
  parameter int LOCK_CYC = 20000,
  parameter int RST_BIT  = 8,
  parameter int TST_BIT  = 7,
  parameter int OFF_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_cfg,
  input  logic [ADDR_W-1:0] emode_cfg,
  input  logic              dll_rst_req,
  input  logic              freq_chg_req,
  input  logic              clk_stable,
  output logic              cmd_vld,
  output logic              cmd_type,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              pd_allow,
  output logic              traffic_allow,
  output logic              busy
);
  localparam int PD_W   = $clog2(PD_GAP + 1);
  localparam int LOCK_W = $clog2(LOCK_CYC + 1);

  logic      rs_meta_q, rs_n;
  cmd_kind_e kind;
  logic      seq_busy;
  logic      pd_busy, lock_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_n      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_n      <= rs_meta_q;
    end
  end

  dll_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rs_n),
    .dll_rst_req  (dll_rst_req),
    .freq_chg_req (freq_chg_req),
    .clk_stable   (clk_stable),
    .lock_busy    (lock_busy),
    .kind         (kind),
    .seq_busy     (seq_busy)
  );

  dll_cmd_enc #(
    .ADDR_W  (ADDR_W),
    .RST_BIT (RST_BIT),
    .TST_BIT (TST_BIT),
    .OFF_BIT (OFF_BIT)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rs_n),
    .kind      (kind),
    .mode_cfg  (mode_cfg),
    .emode_cfg (emode_cfg),
    .cmd_vld   (cmd_vld),
    .cmd_type  (cmd_type),
    .cmd_addr  (cmd_addr)
  );

  dll_dn_cnt #(.W(PD_W)) u_pd_cnt (
    .clk      (clk),
    .rst_n    (rs_n),
    .load     (kind == KIND_RST),
    .load_val (PD_W'(PD_GAP)),
    .running  (pd_busy)
  );

  dll_dn_cnt #(.W(LOCK_W)) u_lock_cnt (
    .clk      (clk),
    .rst_n    (rs_n),
    .load     (kind == KIND_ON),
    .load_val (LOCK_W'(LOCK_CYC)),
    .running  (lock_busy)
  );

  assign pd_allow      = ~pd_busy;
  assign traffic_allow = ~lock_busy;
  assign busy          = seq_busy | lock_busy;
endmodule

// File: rtl/dll_seq_chk.sv
module dll_seq_chk #(
  parameter int ADDR_W  = 12,
  parameter int PD_GAP  = 10,
  parameter int RST_BIT = 8,
  parameter int TST_BIT = 7,
  parameter int OFF_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_vld,
  input logic              cmd_type,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              pd_allow,
  input logic              traffic_allow,
  input logic              busy
);
  assert_no_test_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> !cmd_addr[TST_BIT]);

  assert_mrw_sets_reset_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_type == 1'b0) |-> cmd_addr[RST_BIT]);

  assert_pd_blocked_at_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_type == 1'b0) |-> !pd_allow);

  assert_pd_blocked_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_type == 1'b0 && PD_GAP > 1) |=> !pd_allow);

  assert_traffic_drop_on_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(traffic_allow) |-> (cmd_vld && cmd_type == 1'b1 && !cmd_addr[OFF_BIT]));

  assert_busy_in_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !traffic_allow |-> busy);
endmodule

bind dll_seq_ctrl dll_seq_chk #(
  .ADDR_W  (ADDR_W),
  .PD_GAP  (PD_GAP),
  .RST_BIT (RST_BIT),
  .TST_BIT (TST_BIT),
  .OFF_BIT (OFF_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rs_n),
  .cmd_vld       (cmd_vld),
  .cmd_type      (cmd_type),
  .cmd_addr      (cmd_addr),
  .pd_allow      (pd_allow),
  .traffic_allow (traffic_allow),
  .busy          (busy)
);

// File: tb/dll_seq_ctrl_bench.sv
`timescale 1ns/1ps
module dll_seq_ctrl_bench;
  localparam int LOCK = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] mode_cfg, emode_cfg;
  logic        dll_rst_req, freq_chg_req, clk_stable;
  logic        cmd_vld, cmd_type;
  logic [11:0] cmd_addr;
  logic        pd_allow, traffic_allow, busy;

  int errors = 0;
  int checks = 0;
  logic [12:0] expq[$];

  always #2 clk = ~clk;

  dll_seq_ctrl #(.LOCK_CYC(LOCK)) u_dll_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .emode_cfg(emode_cfg),
    .dll_rst_req(dll_rst_req), .freq_chg_req(freq_chg_req), .clk_stable(clk_stable),
    .cmd_vld(cmd_vld), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
    .pd_allow(pd_allow), .traffic_allow(traffic_allow), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every strobe against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_vld) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6/R8 unexpected command", {cmd_type, cmd_addr}, 0);
      end else begin
        logic [12:0] e;
        e = expq.pop_front();
        check({cmd_type, cmd_addr} == e, "R2/R3/R5/R6 command", {cmd_type, cmd_addr}, e);
      end
    end
  end

  task automatic push_rst(input logic [11:0] m);
    expq.push_back({1'b0, (m | 12'h100) & ~12'h080});
  endtask
  task automatic push_off(input logic [11:0] e);
    expq.push_back({1'b1, (e | 12'h001) & ~12'h080});
  endtask
  task automatic push_on(input logic [11:0] e);
    expq.push_back({1'b1, e & ~12'h081});
  endtask

  task automatic pulse_rst();
    dll_rst_req = 1'b1; @(negedge clk); dll_rst_req = 1'b0;
  endtask
  task automatic pulse_frq();
    freq_chg_req = 1'b1; @(negedge clk); freq_chg_req = 1'b0;
  endtask

  // count low cycles of a flag over a window; also check busy while traffic low
  task automatic count_low(input bit which_pd, input int win, output int lows);
    lows = 0;
    for (int i = 0; i < win; i++) begin
      if (which_pd ? !pd_allow : !traffic_allow) begin
        lows++;
        if (!which_pd && !busy) check(1'b0, "R7 busy during lock", busy, 1);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lows;
    rst_n = 1'b0; dll_rst_req = 0; freq_chg_req = 0; clk_stable = 1;
    mode_cfg = 12'h0A5; emode_cfg = 12'h0C2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!cmd_vld, "R1 cmd_vld", cmd_vld, 0);
    check(pd_allow, "R1 pd_allow", pd_allow, 1);
    check(traffic_allow, "R1 traffic_allow", traffic_allow, 1);
    check(!busy, "R1 busy", busy, 0);

    // R3/R4: DLL reset, bit 7 of config set (R2)
    push_rst(mode_cfg);
    pulse_rst();
    count_low(1'b1, 20, lows);
    check(lows == 10, "R4 pd lockout length", lows, 10);
    check(expq.size() == 0, "R3 reset issued", expq.size(), 0);

    // R5/R6/R8: frequency change with reset arriving mid-sequence
    push_off(emode_cfg);
    pulse_frq();
    repeat (5) @(negedge clk);
    check(traffic_allow, "R5 traffic during clock wait", traffic_allow, 1);
    check(busy, "R8 busy during sequence", busy, 1);
    check(expq.size() == 0, "R5 off issued", expq.size(), 0);
    clk_stable = 1'b0;
    pulse_rst();
    repeat (4) @(negedge clk);
    check(pd_allow, "R8 reset held pending", pd_allow, 1);
    push_on(emode_cfg);
    push_rst(mode_cfg);
    clk_stable = 1'b1;
    @(negedge clk);
    count_low(1'b0, 60, lows);
    check(lows == LOCK, "R7 lock wait length", lows, LOCK);
    check(expq.size() == 0, "R8 pending reset served", expq.size(), 0);
    repeat (12) @(negedge clk);
    check(!busy, "R8 busy released", busy, 0);

    // R8 priority: both requests together; new config values
    mode_cfg = 12'hE7F; emode_cfg = 12'h3B0;
    push_rst(mode_cfg);
    push_off(emode_cfg);
    dll_rst_req = 1'b1; freq_chg_req = 1'b1;
    @(negedge clk);
    dll_rst_req = 1'b0; freq_chg_req = 1'b0;
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R8 priority order", expq.size(), 0);
    // R6: clock stays high, no enable must come
    repeat (10) @(negedge clk);
    check(traffic_allow, "R6 no enable without clock drop", traffic_allow, 1);
    clk_stable = 1'b0; @(negedge clk);
    push_on(emode_cfg);
    clk_stable = 1'b1;
    @(negedge clk);
    count_low(1'b0, 60, lows);
    check(lows == LOCK, "R7 second lock wait", lows, LOCK);
    check(expq.size() == 0, "R6 enable issued", expq.size(), 0);
    check(!busy, "R7 busy cleared", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule